// File: doc/BRIEF.md
# Register-Write Command Queue Executor

The executor walks a packed instruction stream held in memory, from a current-head pointer up to a tail pointer, and turns it into writes on a simple register bus. Each instruction takes two 32-bit words. The data or count word comes first. The second word carries the opcode, four byte-lane enables and a 20-bit register offset. Apart from plain and burst register writes, the stream can also pause on display timing: a number of microseconds, a target scanline, a number of vblank pulses, or while the scanline sits inside or outside an inclusive window. It can also raise an interrupt pulse.

Software loads a start address through the head-load strobe and then writes a tail that is a multiple of 64 bytes while the block is enabled. This starts a run. The run can be held until the next vblank, and it can be frozen at any instruction-word boundary with the halt input. The memory request, memory response and register write ports are valid/ready channels with one transfer outstanding at a time. A stalled request or write keeps its valid high and its payload unchanged until the partner raises ready. The engine accepts no new response until it has asked for one, and it only raises its response ready while it waits for that word.

Top module: `cqx_exec`

## Requirements
- R1: After reset, busy, the memory request valid and the register write valid are low, and the current head reads 0.
- R2: A run starts only on a tail write made while enable is high with tail bits 5:0 equal to zero. A misaligned tail or a write made while disabled is ignored. A head load clears the address bits 2:0.
- R3: With the vblank-gate input high at start, no memory request is issued until the next vblank pulse.
- R4: The upper word holds the opcode in bits 31:24, the lane enables in 23:20 and the offset in 19:0. Opcode 0x1 makes one write of the lower word to that offset. Enable bit 3 drives bits 31:24 and bit 0 drives bits 7:0. Disabled lanes read zero on the bus.
- R5: Opcode 0x9 writes the N words that follow (N is the lower word) to one offset with all lanes enabled. When N is odd, the padding word after them is skipped unread. N of zero writes nothing.
- R6: Opcode 0x2 holds the next instruction back for (lower word) × CYC_PER_US cycles.
- R7: Opcode 0x3 stalls until the scanline input equals lower-word bits SL_W-1:0.
- R8: Opcode 0x4 stalls until the number of vblank pulses given in the lower word has arrived.
- R9: Opcode 0x5 stalls while low ≤ scanline ≤ high, and opcode 0x6 stalls while the scanline is outside that window. The low bound is in lower-word bits starting at 0 and the high bound in bits starting at 20.
- R10: Opcode 0x7 gives a one-cycle interrupt pulse.
- R11: Opcode 0x0 and every undefined opcode (0xA included) are consumed without a write.
- R12: While halt is high, no new memory request is issued. The run resumes when halt falls.
- R13: When the current head reaches the tail, busy falls, done pulses for one cycle and the current head equals the tail.
- R14: A memory request or register write that is not accepted keeps valid high and its payload stable until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_enable | input | 1 | Allows a tail write to start a run |
| ctl_halt | input | 1 | Freezes fetching |
| ctl_vblank_gate | input | 1 | Start waits for next vblank |
| head_wr | input | 1 | Load head pointer strobe |
| head_val | input | AW | Head byte address |
| tail_wr | input | 1 | Tail write strobe (start) |
| tail_val | input | AW | Tail byte address |
| busy_o | output | 1 | Run in progress |
| cur_head_o | output | AW | Current-head byte address |
| done_o | output | 1 | One-cycle end-of-run pulse |
| irq_o | output | 1 | Interrupt instruction pulse |
| mem_req_valid | output | 1 | Word fetch request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | AW | Byte address of word |
| mem_rsp_valid | input | 1 | Fetched word valid |
| mem_rsp_ready | output | 1 | Engine takes the word |
| mem_rsp_data | input | 32 | Fetched word |
| reg_valid | output | 1 | Register write valid |
| reg_ready | input | 1 | Register target accepts |
| reg_addr | output | 20 | Register offset |
| reg_data | output | 32 | Write data, disabled lanes zero |
| reg_be | output | 4 | Byte-lane enables |
| scanline | input | SL_W | Current display line |
| vblank_pulse | input | 1 | One-cycle vblank start |

## Verification
A wrong pointer or phase state shows up at the ports within one instruction. Words that are read out of place put opcodes on the data lanes, so the offset or data of the next register write is wrong, or the pad word appears as a write. A wrong burst count or wait counter shows up as one write too many or too few, or as a write whose cycle stamp falls before the wait window has run out. A stuck state never raises done, and the bench catches that through its per-run timeout. Errors in the lane mask appear in the first write whose enables are partial.

// File: rtl/cqx_pkg.sv
package cqx_pkg;
  localparam logic [7:0] OP_NOP   = 8'h00;
  localparam logic [7:0] OP_WR    = 8'h01;
  localparam logic [7:0] OP_USEC  = 8'h02;
  localparam logic [7:0] OP_LINE  = 8'h03;
  localparam logic [7:0] OP_VBL   = 8'h04;
  localparam logic [7:0] OP_IN    = 8'h05;
  localparam logic [7:0] OP_OUT   = 8'h06;
  localparam logic [7:0] OP_IRQ   = 8'h07;
  localparam logic [7:0] OP_BURST = 8'h09;

  typedef enum logic [3:0] {
    S_IDLE, S_ARM, S_NEXT, S_GATE, S_REQ, S_RSP, S_DISP, S_WRITE, S_WAIT
  } state_e;

  typedef enum logic [1:0] {PH_LO, PH_HI, PH_DATA} phase_e;
endpackage

// File: rtl/cqx_lane_mask.sv
module cqx_lane_mask #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] din,
  input  logic [LANES-1:0]   en,
  output logic [LANES*8-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[g*8 +: 8] = en[g] ? din[g*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/cqx_wait_unit.sv
module cqx_wait_unit
  import cqx_pkg::*;
#(
  parameter int SL_W       = 12,
  parameter int CNT_W      = 16,
  parameter int CYC_PER_US = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       op,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SL_W-1:0]  lo_b,
  input  logic [SL_W-1:0]  hi_b,
  input  logic [SL_W-1:0]  scanline,
  input  logic             vblank_pulse,
  output logic             fin
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);

  logic             active;
  logic [7:0]       op_q;
  logic [CNT_W-1:0] rem;
  logic [PW-1:0]    pre;
  logic [SL_W-1:0]  lo_q, hi_q;
  logic             met, in_win;

  assign in_win = (scanline >= lo_q) && (scanline <= hi_q);

  always_comb begin
    case (op_q)
      OP_USEC: met = (rem == '0);
      OP_VBL:  met = (rem == '0);
      OP_LINE: met = (scanline == lo_q);
      OP_IN:   met = !in_win;
      OP_OUT:  met = in_win;
      default: met = 1'b1;
    endcase
  end

  assign fin = active && met;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      op_q   <= OP_NOP;
      rem    <= '0;
      pre    <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (start) begin
      active <= 1'b1;
      op_q   <= op;
      rem    <= cnt;
      pre    <= '0;
      lo_q   <= lo_b;
      hi_q   <= hi_b;
    end else if (active) begin
      if (met) begin
        active <= 1'b0;
      end else if (op_q == OP_USEC) begin
        if (pre == PRE_LAST) begin
          pre <= '0;
          rem <= rem - 1'b1;
        end else begin
          pre <= pre + 1'b1;
        end
      end else if (op_q == OP_VBL && vblank_pulse) begin
        rem <= rem - 1'b1;
      end
    end
  end

  // R6
  wait_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !met && !start) |=> (rem <= $past(rem)));
endmodule

// File: rtl/cqx_exec.sv
module cqx_exec
  import cqx_pkg::*;
#(
  parameter int AW         = 16,
  parameter int SL_W       = 12,
  parameter int CNT_W      = 16,
  parameter int CYC_PER_US = 250
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_enable,
  input  logic            ctl_halt,
  input  logic            ctl_vblank_gate,
  input  logic            head_wr,
  input  logic [AW-1:0]   head_val,
  input  logic            tail_wr,
  input  logic [AW-1:0]   tail_val,
  output logic            busy_o,
  output logic [AW-1:0]   cur_head_o,
  output logic            done_o,
  output logic            irq_o,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [31:0]     mem_rsp_data,
  output logic            reg_valid,
  input  logic            reg_ready,
  output logic [19:0]     reg_addr,
  output logic [31:0]     reg_data,
  output logic [3:0]      reg_be,
  input  logic [SL_W-1:0] scanline,
  input  logic            vblank_pulse
);
  localparam int HI_BOUND_POS = 20;

  state_e           state;
  phase_e           phase;
  logic [AW-1:0]    ptr, tail_q;
  logic [31:0]      lo_q, hi_q, wdata_q;
  logic [3:0]       wbe_q;
  logic [CNT_W-1:0] left_q;
  logic             done_q, irq_q;
  logic [7:0]       op;
  logic             is_wait, wait_start, wait_fin;

  assign op = hi_q[31:24];
  assign is_wait = (op == OP_USEC) || (op == OP_LINE) || (op == OP_VBL) ||
                   (op == OP_IN) || (op == OP_OUT);
  assign wait_start = (state == S_DISP) && is_wait;

  assign busy_o        = (state != S_IDLE);
  assign cur_head_o    = ptr;
  assign done_o        = done_q;
  assign irq_o         = irq_q;
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr  = ptr;
  assign mem_rsp_ready = (state == S_RSP);
  assign reg_valid     = (state == S_WRITE);
  assign reg_addr      = hi_q[19:0];
  assign reg_be        = wbe_q;

  cqx_lane_mask #(.LANES(4)) u_mask (
    .din (wdata_q),
    .en  (wbe_q),
    .dout(reg_data)
  );

  cqx_wait_unit #(.SL_W(SL_W), .CNT_W(CNT_W), .CYC_PER_US(CYC_PER_US)) u_wait (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (wait_start),
    .op          (op),
    .cnt         (lo_q[CNT_W-1:0]),
    .lo_b        (lo_q[SL_W-1:0]),
    .hi_b        (lo_q[HI_BOUND_POS +: SL_W]),
    .scanline    (scanline),
    .vblank_pulse(vblank_pulse),
    .fin         (wait_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= PH_LO;
      ptr     <= '0;
      tail_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      wdata_q <= '0;
      wbe_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (head_wr) ptr <= {head_val[AW-1:3], 3'b000};
          if (tail_wr && ctl_enable && tail_val[5:0] == 6'd0) begin
            tail_q <= tail_val;
            state  <= ctl_vblank_gate ? S_ARM : S_NEXT;
          end
        end
        S_ARM: if (vblank_pulse) state <= S_NEXT;
        S_NEXT: begin
          if (ptr == tail_q) begin
            state  <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            phase <= PH_LO;
            state <= S_GATE;
          end
        end
        S_GATE: if (!ctl_halt) state <= S_REQ;
        S_REQ:  if (mem_req_ready) state <= S_RSP;
        S_RSP: begin
          if (mem_rsp_valid) begin
            ptr <= ptr + AW'(4);
            case (phase)
              PH_LO: begin
                lo_q  <= mem_rsp_data;
                phase <= PH_HI;
                state <= S_GATE;
              end
              PH_HI: begin
                hi_q  <= mem_rsp_data;
                state <= S_DISP;
              end
              default: begin
                wdata_q <= mem_rsp_data;
                wbe_q   <= 4'hF;
                state   <= S_WRITE;
              end
            endcase
          end
        end
        S_DISP: begin
          if (op == OP_WR) begin
            wdata_q <= lo_q;
            wbe_q   <= hi_q[23:20];
            state   <= S_WRITE;
          end else if (op == OP_BURST) begin
            if (lo_q[CNT_W-1:0] == '0) begin
              state <= S_NEXT;
            end else begin
              left_q <= lo_q[CNT_W-1:0];
              phase  <= PH_DATA;
              state  <= S_GATE;
            end
          end else if (is_wait) begin
            state <= S_WAIT;
          end else begin
            if (op == OP_IRQ) irq_q <= 1'b1;
            state <= S_NEXT;
          end
        end
        S_WRITE: begin
          if (reg_ready) begin
            if (phase == PH_DATA) begin
              if (left_q == CNT_W'(1)) begin
                if (lo_q[0]) ptr <= ptr + AW'(4);
                state <= S_NEXT;
              end else begin
                left_q <= left_q - 1'b1;
                state  <= S_GATE;
              end
            end else begin
              state <= S_NEXT;
            end
          end
        end
        S_WAIT:  if (wait_fin) state <= S_NEXT;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R14
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_ready) |=> (reg_valid && $stable(reg_addr) &&
                                   $stable(reg_data) && $stable(reg_be)));
  // R14
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R12
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> !$past(ctl_halt));
  // R5
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_NEXT) |-> (ptr[2:0] == 3'd0));
  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

// File: tb/cqx_exec_tb.sv
module cqx_exec_tb_top;
  localparam int AW  = 16;
  localparam int SLW = 12;
  localparam int CPU = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ctl_enable = 1'b1, ctl_halt = 1'b0, ctl_vblank_gate = 1'b0;
  logic head_wr = 1'b0, tail_wr = 1'b0;
  logic [AW-1:0] head_val = '0, tail_val = '0;
  logic busy_o, done_o, irq_o;
  logic [AW-1:0] cur_head_o;
  logic mem_req_valid, mem_req_ready, mem_rsp_ready;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic reg_valid, reg_ready = 1'b0;
  logic [19:0] reg_addr;
  logic [31:0] reg_data;
  logic [3:0] reg_be;
  logic [SLW-1:0] scanline = '0;
  logic vblank_pulse = 1'b0;

  assign mem_req_ready = 1'b1;

  cqx_exec #(.AW(AW), .SL_W(SLW), .CNT_W(16), .CYC_PER_US(CPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_halt(ctl_halt),
    .ctl_vblank_gate(ctl_vblank_gate), .head_wr(head_wr), .head_val(head_val),
    .tail_wr(tail_wr), .tail_val(tail_val), .busy_o(busy_o), .cur_head_o(cur_head_o),
    .done_o(done_o), .irq_o(irq_o), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_addr(reg_addr), .reg_data(reg_data), .reg_be(reg_be),
    .scanline(scanline), .vblank_pulse(vblank_pulse)
  );

  // memory model and bus observers
  logic [31:0] mem [128];
  int cyc = 0, n_wr = 0, n_req = 0, n_done = 0, n_irq = 0;
  logic [19:0] log_addr [64];
  logic [31:0] log_data [64];
  logic [3:0]  log_be   [64];
  int          log_cyc  [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    reg_ready <= (cyc % 3) != 0;
    if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[mem_req_addr[8:2]];
      n_req <= n_req + 1;
    end
    if (reg_valid && reg_ready) begin
      log_addr[n_wr % 64] <= reg_addr;
      log_data[n_wr % 64] <= reg_data;
      log_be[n_wr % 64]   <= reg_be;
      log_cyc[n_wr % 64]  <= cyc;
      n_wr <= n_wr + 1;
    end
    if (done_o) n_done <= n_done + 1;
    if (irq_o)  n_irq  <= n_irq + 1;
  end

  int n_chk = 0, n_bad = 0;
  int start_cyc = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] up(input logic [7:0] op, input logic [3:0] be,
                                     input logic [19:0] off);
    return {op, be, off};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
  endtask

  task automatic put(input int slot, input logic [31:0] lo, input logic [31:0] hi);
    mem[2*slot] = lo;
    mem[2*slot+1] = hi;
  endtask

  task automatic start(input logic [AW-1:0] tail);
    @(negedge clk);
    head_wr = 1'b1; head_val = '0;
    @(negedge clk);
    head_wr = 1'b0; tail_wr = 1'b1; tail_val = tail;
    start_cyc = cyc;
    @(negedge clk);
    tail_wr = 1'b0;
  endtask

  task automatic wait_done(input int base, input string req);
    int k;
    k = 0;
    while (n_done == base && k < 2000) begin
      @(negedge clk);
      k++;
    end
    check(n_done == base + 1, req, n_done - base, 1);
  endtask

  task automatic pulse_vbl();
    @(negedge clk); vblank_pulse = 1'b1;
    @(negedge clk); vblank_pulse = 1'b0;
  endtask

  // {be, data, expected bus data}
  localparam logic [67:0] VEC [6] = '{
    {4'hF, 32'hA1B2C3D4, 32'hA1B2C3D4},
    {4'h1, 32'hA1B2C3D4, 32'h000000D4},
    {4'h8, 32'hA1B2C3D4, 32'hA1000000},
    {4'h6, 32'hA1B2C3D4, 32'h00B2C300},
    {4'h0, 32'hA1B2C3D4, 32'h00000000},
    {4'h5, 32'h12345678, 32'h00340078}
  };

  task automatic run_all();
    int b, d;
    // R1 reset state
    check(busy_o == 1'b0, "R1 busy", busy_o, 0);
    check(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
    check(reg_valid == 1'b0, "R1 reg_valid", reg_valid, 0);
    check(cur_head_o == '0, "R1 cur_head", cur_head_o, 0);

    // R4 / R14 vector table walk under reg back-pressure
    for (int v = 0; v < 6; v++) begin
      clear_mem();
      put(0, VEC[v][63:32], up(8'h01, VEC[v][67:64], 20'h00ABC + 20'(v)));
      b = n_wr; d = n_done;
      start(16'd64);
      wait_done(d, "R13 vec done");
      check(n_wr == b + 1, "R4 vec count", n_wr - b, 1);
      check(log_data[b%64] == VEC[v][31:0], "R4 R14 vec data", log_data[b%64], VEC[v][31:0]);
      check(log_be[b%64] == VEC[v][67:64], "R4 vec be", log_be[b%64], VEC[v][67:64]);
      check(log_addr[b%64] == 20'h00ABC + 20'(v), "R4 vec addr", log_addr[b%64], 20'h00ABC + 20'(v));
    end

    // R5 odd burst with poisoned pad, then plain write; R13 head/done
    clear_mem();
    put(0, 32'd3, up(8'h09, 4'h0, 20'h00100));
    mem[2] = 32'h11; mem[3] = 32'h22; mem[4] = 32'h33; mem[5] = 32'hDEADBEEF;
    put(3, 32'h55, up(8'h01, 4'hF, 20'h00200));
    b = n_wr; d = n_done;
    start(16'd64);
    wait_done(d, "R13 burst done");
    repeat (3) @(negedge clk);
    check(n_done == d + 1, "R13 single done", n_done - d, 1);
    check(n_wr == b + 4, "R5 odd count", n_wr - b, 4);
    check(log_data[(b+2)%64] == 32'h33 && log_addr[(b+2)%64] == 20'h00100, "R5 third word",
          log_data[(b+2)%64], 32'h33);
    check(log_be[(b+1)%64] == 4'hF, "R5 full lanes", log_be[(b+1)%64], 4'hF);
    check(log_data[(b+3)%64] == 32'h55 && log_addr[(b+3)%64] == 20'h00200, "R5 pad skipped",
          log_data[(b+3)%64], 32'h55);
    check(cur_head_o == 16'd64 && !busy_o, "R13 head at tail", cur_head_o, 64);

    // R5 even burst and zero-count burst
    clear_mem();
    put(0, 32'd2, up(8'h09, 4'h0, 20'h00110));
    mem[2] = 32'hA; mem[3] = 32'hB;
    put(2, 32'd0, up(8'h09, 4'h0, 20'h00120));
    put(3, 32'h66, up(8'h01, 4'hF, 20'h00210));
    b = n_wr; d = n_done;
    start(16'd64);
    wait_done(d, "R13 even done");
    check(n_wr == b + 3, "R5 even/zero count", n_wr - b, 3);
    check(log_data[(b+2)%64] == 32'h66, "R5 after even", log_data[(b+2)%64], 32'h66);

    // R6 microsecond wait
    clear_mem();
    put(0, 32'd3, up(8'h02, 4'h0, 20'h0));
    put(1, 32'h77, up(8'h01, 4'hF, 20'h00300));
    b = n_wr; d = n_done;
    start(16'd64);
    wait_done(d, "R6 done");
    check(log_cyc[b%64] - start_cyc >= 3*CPU, "R6 not early", log_cyc[b%64] - start_cyc, 3*CPU);
    check(log_cyc[b%64] - start_cyc <= 3*CPU + 40, "R6 not late", log_cyc[b%64] - start_cyc, 3*CPU + 40);

    // R7 scanline wait
    clear_mem();
    scanline = 12'd0;
    put(0, 32'd5, up(8'h03, 4'h0, 20'h0));
    put(1, 32'h88, up(8'h01, 4'hF, 20'h00310));
    b = n_wr; d = n_done;
    start(16'd64);
    repeat (60) @(negedge clk);
    check(n_wr == b && busy_o, "R7 stalled", n_wr - b, 0);
    scanline = 12'd5;
    wait_done(d, "R7 done");
    check(n_wr == b + 1 && log_data[b%64] == 32'h88, "R7 released", log_data[b%64], 32'h88);

    // R8 vblank count
    clear_mem();
    put(0, 32'd2, up(8'h04, 4'h0, 20'h0));
    put(1, 32'h99, up(8'h01, 4'hF, 20'h00320));
    b = n_wr; d = n_done;
    start(16'd64);
    repeat (20) @(negedge clk);
    pulse_vbl();
    repeat (20) @(negedge clk);
    check(n_wr == b, "R8 one vblank not enough", n_wr - b, 0);
    pulse_vbl();
    wait_done(d, "R8 done");
    check(n_wr == b + 1, "R8 released", n_wr - b, 1);

    // R9 inside window, bounds 3..7
    clear_mem();
    scanline = 12'd4;
    put(0, (32'd7 << 20) | 32'd3, up(8'h05, 4'h0, 20'h0));
    put(1, 32'hAA, up(8'h01, 4'hF, 20'h00330));
    b = n_wr; d = n_done;
    start(16'd64);
    repeat (40) @(negedge clk);
    check(n_wr == b, "R9 inside stalls", n_wr - b, 0);
    scanline = 12'd9;
    wait_done(d, "R9 inside done");
    check(n_wr == b + 1, "R9 inside released", n_wr - b, 1);

    // R9 outside window
    clear_mem();
    scanline = 12'd1;
    put(0, (32'd7 << 20) | 32'd3, up(8'h06, 4'h0, 20'h0));
    put(1, 32'hBB, up(8'h01, 4'hF, 20'h00340));
    b = n_wr; d = n_done;
    start(16'd64);
    repeat (40) @(negedge clk);
    check(n_wr == b, "R9 outside stalls", n_wr - b, 0);
    scanline = 12'd7;
    wait_done(d, "R9 outside done");
    check(n_wr == b + 1, "R9 outside released", n_wr - b, 1);

    // R10 interrupt pulses
    clear_mem();
    put(0, 32'd0, up(8'h07, 4'h0, 20'h0));
    put(1, 32'd0, up(8'h07, 4'h0, 20'h0));
    b = n_irq; d = n_done;
    start(16'd64);
    wait_done(d, "R10 done");
    check(n_irq == b + 2, "R10 irq count", n_irq - b, 2);

    // R11 unknown opcodes skipped
    clear_mem();
    put(0, 32'h1234, up(8'h0A, 4'hF, 20'h00400));
    put(1, 32'h99, up(8'h0B, 4'hF, 20'h00410));
    put(2, 32'h42, up(8'h01, 4'hF, 20'h00500));
    b = n_wr; d = n_done;
    start(16'd64);
    wait_done(d, "R11 done");
    check(n_wr == b + 1 && log_data[b%64] == 32'h42, "R11 only real write", n_wr - b, 1);

    // R3 vblank gate
    clear_mem();
    put(0, 32'hC3, up(8'h01, 4'hF, 20'h00600));
    ctl_vblank_gate = 1'b1;
    b = n_req; d = n_done;
    start(16'd64);
    ctl_vblank_gate = 1'b0;
    repeat (40) @(negedge clk);
    check(n_req == b && busy_o, "R3 gated", n_req - b, 0);
    pulse_vbl();
    wait_done(d, "R3 done");

    // R2 misaligned tail and disabled start ignored
    b = n_req;
    start(16'd72);
    repeat (10) @(negedge clk);
    check(!busy_o && n_req == b, "R2 misaligned ignored", busy_o, 0);
    ctl_enable = 1'b0;
    start(16'd64);
    repeat (10) @(negedge clk);
    check(!busy_o && n_req == b, "R2 disabled ignored", busy_o, 0);
    ctl_enable = 1'b1;

    // R12 halt
    ctl_halt = 1'b1;
    b = n_req; d = n_done;
    start(16'd64);
    repeat (30) @(negedge clk);
    check(n_req == b && busy_o, "R12 halted", n_req - b, 0);
    ctl_halt = 1'b0;
    wait_done(d, "R12 resumed");
  endtask

  initial begin
    clear_mem();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule